// File: doc/BRIEF.md
# Phase-Interleaved Memory Copy Engine

This block copies bytes from one memory region to another over a bus it shares with a simple 8-bit processor. Each bus cycle is split into two halves. The engine may use only the first half, and the processor always owns the second half. Because the engine keeps out of the processor's half, the processor never waits and needs no hold line. The engine runs on a clock at twice the bus rate. It generates the phase itself and publishes it on `phi2`, so one engine clock equals one half of a bus cycle.

Software sets up the copy through a small byte-wide register port. It writes a 16-bit source address, a 16-bit destination address and a 16-bit byte count, then writes the control register with the start bit set. Each byte takes two first-half slots: a read slot at the source address, then a write slot at the destination address that carries the byte read. Both addresses move one step per byte, up or down. An optional paced mode waits for a peripheral request before each read and answers with an active-low acknowledge in that read slot. Page zero (addresses `0x0000` to `0x00FF`) is protected: the engine stops with an error rather than touch it. When a copy finishes or is aborted, a done flag or an error flag is set, and an interrupt can be raised.

Top module: `phase_dma`

## Requirements
- R1: `phi2` alternates on every clock after reset. `bus_addr_oe` and `bus_data_oe` are asserted only in cycles where `phi2` is low.
- R2: Each byte is read in one slot with `bus_rw`=1 at the source address. The next slot with `phi2` low is a write (`bus_rw`=0) at the destination address, and `bus_wdata` in that slot equals the byte read.
- R3: After each byte, the source and destination addresses both step by +1 when the direction bit is 0, or by -1 when it is 1. The live source value can be read back through the register port.
- R4: The count register decreases by one per byte written and reads 0 after a completed copy. A count of 0 at start means 65536 bytes.
- R5: When the last byte has been written, busy clears and done sets. Exactly `count` write slots occur.
- R6: `irq` is high while interrupt-enable is 1 and done or error is set. It is low otherwise.
- R7: In paced mode (control bit 2), a read slot happens only if `dreq` was high at the clock edge that starts the slot. `dack_n` is low only in such a read slot, and it never goes low in unpaced mode.
- R8: The engine never drives an address whose upper byte is zero. If the next source or destination address lies in page zero, the engine sets error, clears busy, leaves done at 0 and stops.
- R9: Writing 1 to status bit 1 clears done, and writing 1 to status bit 2 clears error. A start clears both flags.
- R10: While busy, writes to registers 0 to 6 are ignored, and this includes the start bit.
- R11: Reset leaves busy, done, error and `irq` at 0, with `bus_addr_oe` and `bus_data_oe` at 0 and `dack_n` at 1.
- R12: Register map, byte-wide, with read data registered one clock after `reg_addr`:
  - 0/1: source low and high byte.
  - 2/3: destination low and high byte.
  - 4/5: count low and high byte.
  - 6: control. Bit 0 is start (write only), bit 1 is direction, bit 2 is paced mode, bit 3 is interrupt-enable.
  - 7: status. Bit 0 is busy, bit 1 is done, bit 2 is error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Engine clock, twice the bus rate |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data |
| irq | output | 1 | Interrupt request |
| phi2 | output | 1 | High in the processor's half of the bus cycle |
| bus_addr | output | 16 | Bus address driven by the engine |
| bus_rw | output | 1 | 1 = read, 0 = write |
| bus_addr_oe | output | 1 | Enable for address and read/write drivers |
| bus_rdata | input | 8 | Data returned by memory during a read slot |
| bus_wdata | output | 8 | Data driven during a write slot |
| bus_data_oe | output | 1 | Enable for data drivers |
| dreq | input | 1 | Peripheral request, active high |
| dack_n | output | 1 | Acknowledge, active low |

## Verification
Several unpaced copies use random lengths, random start addresses and random directions. Comparing every driven address and written byte against the computed sequence separates correct stepping and byte order from off-by-one and wrong-direction faults. Paced copies use random request patterns, and one copy holds the request low, which shows whether reads truly wait and whether register writes are locked while busy. Two aborts test the page-zero check. The first is a source that walks down into page zero under a zero count, which also confirms that zero means 65536. The second is a destination that starts inside page zero, which shows that the read slot still ran but no write slot followed.

// File: rtl/phase_dma_pkg.sv
package phase_dma_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR} xfer_st_t;
  typedef enum logic [1:0] {SL_NONE, SL_RD, SL_WR} slot_t;

  localparam logic [2:0] RA_SRC_LO = 3'd0;
  localparam logic [2:0] RA_SRC_HI = 3'd1;
  localparam logic [2:0] RA_DST_LO = 3'd2;
  localparam logic [2:0] RA_DST_HI = 3'd3;
  localparam logic [2:0] RA_CNT_LO = 3'd4;
  localparam logic [2:0] RA_CNT_HI = 3'd5;
  localparam logic [2:0] RA_CTRL   = 3'd6;
  localparam logic [2:0] RA_STAT   = 3'd7;
  localparam int         NUM_LOADABLE = 6;
endpackage

// File: rtl/dma_step_ctr.sv
module dma_step_ctr #(
  parameter int W  = 16,
  parameter int LW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [W/LW-1:0] ld,
  input  logic [LW-1:0]   din,
  input  logic            step,
  input  logic            down,
  output logic [W-1:0]    q
);
  localparam int NL = W / LW;

  logic [W-1:0] nxt;

  always_comb begin
    nxt = q;
    if (step) nxt = down ? q - W'(1) : q + W'(1);
    for (int i = 0; i < NL; i++) begin
      if (ld[i]) nxt[i*LW +: LW] = din;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= nxt;
  end
endmodule

// File: rtl/dma_regs.sv
module dma_regs
  import phase_dma_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic [2:0]    addr,
  input  logic [3:0]    ctl_bits,
  output logic [7:0]    rdata,
  input  logic          busy_i,
  input  logic          done_p,
  input  logic          err_p,
  input  logic [AW-1:0] src_q,
  input  logic [AW-1:0] dst_q,
  input  logic [CW-1:0] cnt_q,
  output logic [NUM_LOADABLE-1:0] ld,
  output logic          start_p,
  output logic          dir,
  output logic          paced,
  output logic          irq
);
  logic ie_q, paced_q, dir_q, done_q, err_q, irq_q;
  logic ctrl_wr, stat_wr;

  for (genvar g = 0; g < NUM_LOADABLE; g++) begin : g_ld
    assign ld[g] = wr && (addr == 3'(g)) && !busy_i;
  end

  assign ctrl_wr = wr && (addr == RA_CTRL) && !busy_i;
  assign stat_wr = wr && (addr == RA_STAT);
  assign start_p = ctrl_wr && ctl_bits[0];
  assign dir     = dir_q;
  assign paced   = paced_q;
  assign irq     = irq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ie_q    <= 1'b0;
      paced_q <= 1'b0;
      dir_q   <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      irq_q   <= 1'b0;
      rdata   <= 8'h00;
    end else begin
      if (ctrl_wr) {ie_q, paced_q, dir_q} <= ctl_bits[3:1];
      if (start_p) begin
        done_q <= 1'b0;
        err_q  <= 1'b0;
      end
      if (stat_wr) begin
        if (ctl_bits[1]) done_q <= 1'b0;
        if (ctl_bits[2]) err_q  <= 1'b0;
      end
      if (done_p) done_q <= 1'b1;
      if (err_p)  err_q  <= 1'b1;
      irq_q <= ie_q && (done_q || err_q);
      case (addr)
        RA_SRC_LO: rdata <= src_q[7:0];
        RA_SRC_HI: rdata <= 8'(src_q >> 8);
        RA_DST_LO: rdata <= dst_q[7:0];
        RA_DST_HI: rdata <= 8'(dst_q >> 8);
        RA_CNT_LO: rdata <= cnt_q[7:0];
        RA_CNT_HI: rdata <= 8'(cnt_q >> 8);
        RA_CTRL:   rdata <= {4'b0, ie_q, paced_q, dir_q, 1'b0};
        default:   rdata <= {5'b0, err_q, done_q, busy_i};
      endcase
    end
  end

  p_done_after_busy_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(done_q) |-> $past(busy_i));
  p_ctrl_locked_r10: assert property (@(posedge clk) disable iff (rst)
    (busy_i && wr && addr == RA_CTRL) |=>
      ({ie_q, paced_q, dir_q} == $past({ie_q, paced_q, dir_q})));
  p_irq_needs_flag_r6: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> $past(done_q || err_q));
endmodule

// File: rtl/dma_slot_fsm.sv
module dma_slot_fsm
  import phase_dma_pkg::*;
#(
  parameter int AW        = 16,
  parameter int DW        = 8,
  parameter int PAGE_BITS = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_p,
  input  logic          paced,
  input  logic          dreq_i,
  input  logic [AW-1:0] src_a,
  input  logic [AW-1:0] dst_a,
  input  logic          cnt_last,
  input  logic [DW-1:0] rdata_i,
  output logic          phi2_o,
  output logic [AW-1:0] bus_addr,
  output logic          bus_rw,
  output logic          bus_drive,
  output logic [DW-1:0] bus_wdata,
  output logic          bus_data_oe,
  output logic          dack_n,
  output logic          src_step,
  output logic          dst_step,
  output logic          done_p,
  output logic          err_p,
  output logic          busy
);
  xfer_st_t      st_q;
  slot_t         slot_q;
  logic          ph_q;
  logic [DW-1:0] hold_q;

  function automatic logic in_zp(input logic [AW-1:0] a);
    return a[AW-1:PAGE_BITS] == '0;
  endfunction

  assign phi2_o   = ph_q;
  assign busy     = (st_q != ST_IDLE);
  assign src_step = !ph_q && (slot_q == SL_RD);
  assign dst_step = !ph_q && (slot_q == SL_WR);
  assign done_p   = dst_step && cnt_last;
  assign err_p    = ph_q && (((st_q == ST_RD) && in_zp(src_a)) ||
                             ((st_q == ST_WR) && in_zp(dst_a)));

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q        <= 1'b1;
      st_q        <= ST_IDLE;
      slot_q      <= SL_NONE;
      hold_q      <= '0;
      bus_addr    <= '0;
      bus_rw      <= 1'b1;
      bus_drive   <= 1'b0;
      bus_wdata   <= '0;
      bus_data_oe <= 1'b0;
      dack_n      <= 1'b1;
    end else begin
      ph_q <= ~ph_q;
      if (st_q == ST_IDLE && start_p) st_q <= ST_RD;
      if (ph_q) begin
        slot_q <= SL_NONE;
        case (st_q)
          ST_RD: begin
            if (in_zp(src_a)) begin
              st_q <= ST_IDLE;
            end else if (!paced || dreq_i) begin
              slot_q    <= SL_RD;
              bus_addr  <= src_a;
              bus_rw    <= 1'b1;
              bus_drive <= 1'b1;
              dack_n    <= !paced;
            end
          end
          ST_WR: begin
            if (in_zp(dst_a)) begin
              st_q <= ST_IDLE;
            end else begin
              slot_q      <= SL_WR;
              bus_addr    <= dst_a;
              bus_rw      <= 1'b0;
              bus_drive   <= 1'b1;
              bus_wdata   <= hold_q;
              bus_data_oe <= 1'b1;
            end
          end
          default: ;
        endcase
      end else begin
        bus_drive   <= 1'b0;
        bus_data_oe <= 1'b0;
        dack_n      <= 1'b1;
        slot_q      <= SL_NONE;
        if (slot_q == SL_RD) begin
          hold_q <= rdata_i;
          st_q   <= ST_WR;
        end else if (slot_q == SL_WR) begin
          st_q <= cnt_last ? ST_IDLE : ST_RD;
        end
      end
    end
  end

  p_quiet_in_phi2_r1: assert property (@(posedge clk) disable iff (rst)
    phi2_o |-> (!bus_drive && !bus_data_oe));
  p_phase_alternates_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) || (phi2_o != $past(phi2_o)));
  p_read_then_write_r2: assert property (@(posedge clk) disable iff (rst)
    (bus_drive && bus_rw && !phi2_o) |=> ##1 ((bus_drive && !bus_rw) || !busy));
  p_dack_only_paced_read_r7: assert property (@(posedge clk) disable iff (rst)
    !dack_n |-> (bus_drive && bus_rw && !phi2_o && paced));
  p_read_waits_dreq_r7: assert property (@(posedge clk) disable iff (rst)
    (bus_drive && bus_rw && !phi2_o && paced) |-> $past(dreq_i));
  p_no_zero_page_r8: assert property (@(posedge clk) disable iff (rst)
    bus_drive |-> (bus_addr[AW-1:PAGE_BITS] != '0));
endmodule

// File: rtl/phase_dma.sv
module phase_dma
  import phase_dma_pkg::*;
#(
  parameter int AW        = 16,
  parameter int DW        = 8,
  parameter int CW        = 16,
  parameter int PAGE_BITS = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_wr,
  input  logic [2:0]    reg_addr,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  output logic          irq,
  output logic          phi2,
  output logic [AW-1:0] bus_addr,
  output logic          bus_rw,
  output logic          bus_addr_oe,
  input  logic [DW-1:0] bus_rdata,
  output logic [DW-1:0] bus_wdata,
  output logic          bus_data_oe,
  input  logic          dreq,
  output logic          dack_n
);
  localparam int AL = AW / 8;
  localparam int CL = CW / 8;

  logic [NUM_LOADABLE-1:0] ld;
  logic [AW-1:0] src_q, dst_q;
  logic [CW-1:0] cnt_q;
  logic start_p, dir, paced, busy, done_p, err_p, src_step, dst_step, cnt_last;

  assign cnt_last = (cnt_q == CW'(1));

  dma_regs #(.AW(AW), .CW(CW)) u_regs (
    .clk(clk), .rst(rst), .wr(reg_wr), .addr(reg_addr), .ctl_bits(reg_wdata[3:0]),
    .rdata(reg_rdata), .busy_i(busy), .done_p(done_p), .err_p(err_p),
    .src_q(src_q), .dst_q(dst_q), .cnt_q(cnt_q), .ld(ld), .start_p(start_p),
    .dir(dir), .paced(paced), .irq(irq)
  );

  dma_step_ctr #(.W(AW), .LW(8)) u_src (
    .clk(clk), .rst(rst), .ld(ld[AL-1:0]), .din(reg_wdata),
    .step(src_step), .down(dir), .q(src_q)
  );

  dma_step_ctr #(.W(AW), .LW(8)) u_dst (
    .clk(clk), .rst(rst), .ld(ld[2*AL-1:AL]), .din(reg_wdata),
    .step(dst_step), .down(dir), .q(dst_q)
  );

  dma_step_ctr #(.W(CW), .LW(8)) u_cnt (
    .clk(clk), .rst(rst), .ld(ld[2*AL+CL-1:2*AL]), .din(reg_wdata),
    .step(dst_step), .down(1'b1), .q(cnt_q)
  );

  dma_slot_fsm #(.AW(AW), .DW(DW), .PAGE_BITS(PAGE_BITS)) u_fsm (
    .clk(clk), .rst(rst), .start_p(start_p), .paced(paced), .dreq_i(dreq),
    .src_a(src_q), .dst_a(dst_q), .cnt_last(cnt_last), .rdata_i(bus_rdata),
    .phi2_o(phi2), .bus_addr(bus_addr), .bus_rw(bus_rw), .bus_drive(bus_addr_oe),
    .bus_wdata(bus_wdata), .bus_data_oe(bus_data_oe), .dack_n(dack_n),
    .src_step(src_step), .dst_step(dst_step), .done_p(done_p), .err_p(err_p),
    .busy(busy)
  );
endmodule

// File: tb/phase_dma_test.sv
module phase_dma_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_wr = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic irq, phi2, bus_rw, bus_addr_oe, bus_data_oe, dack_n;
  logic [15:0] bus_addr;
  logic [7:0] bus_rdata, bus_wdata;
  logic dreq = 1'b0;

  int errors = 0;
  int checks = 0;
  int mon_errs = 0;
  int mon_checks = 0;
  int gen = 0;
  int dreq_sel = 0;
  logic [15:0] exp_src = 16'h0, exp_dst = 16'h0;
  logic exp_down = 1'b0;
  int nbytes = 0;

  always #10 clk = ~clk;

  function automatic logic [7:0] pat(input logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[11:8]} ^ 8'h5A;
  endfunction

  function automatic logic [15:0] stp(input logic [15:0] a, input int i, input logic down);
    return down ? a - 16'(i) : a + 16'(i);
  endfunction

  assign bus_rdata = pat(bus_addr);

  phase_dma uut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq), .phi2(phi2), .bus_addr(bus_addr), .bus_rw(bus_rw),
    .bus_addr_oe(bus_addr_oe), .bus_rdata(bus_rdata), .bus_wdata(bus_wdata),
    .bus_data_oe(bus_data_oe), .dreq(dreq), .dack_n(dack_n)
  );

  always @(negedge clk) begin
    case (dreq_sel)
      0: dreq <= 1'b0;
      1: dreq <= 1'b1;
      default: dreq <= 1'($urandom % 2);
    endcase
  end

  // bus monitor: phase rules, address sequence, written data
  int seen_gen = 0;
  int idx = 0;
  logic prev_phi2 = 1'b1;
  logic was_rst = 1'b1;
  always @(negedge clk) begin
    if (gen != seen_gen) begin
      seen_gen = gen; idx = 0; nbytes = 0;
    end
    if (!rst) begin
      if (!was_rst && phi2 == prev_phi2) begin
        mon_errs++; $display("FAIL R1: phi2 did not alternate act=%0d exp=%0d", phi2, !prev_phi2);
      end
      if (phi2 && (bus_addr_oe || bus_data_oe)) begin
        mon_errs++; $display("FAIL R1: drive in phi2 act=%0d exp=0", bus_addr_oe | bus_data_oe);
      end
      if (!dack_n && !(bus_addr_oe && bus_rw && !phi2)) begin
        mon_errs++; $display("FAIL R7: dack outside read slot act=0 exp=1");
      end
      if (!phi2 && bus_addr_oe && bus_rw) begin
        mon_checks++;
        if (bus_addr != stp(exp_src, idx, exp_down)) begin
          mon_errs++;
          $display("FAIL R3: read addr act=%h exp=%h", bus_addr, stp(exp_src, idx, exp_down));
        end
      end
      if (!phi2 && bus_addr_oe && !bus_rw) begin
        mon_checks++;
        if (bus_addr != stp(exp_dst, idx, exp_down) || !bus_data_oe ||
            bus_wdata != pat(stp(exp_src, idx, exp_down))) begin
          mon_errs++;
          $display("FAIL R2: write act=%h/%h exp=%h/%h", bus_addr, bus_wdata,
                   stp(exp_dst, idx, exp_down), pat(stp(exp_src, idx, exp_down)));
        end
        idx++; nbytes++;
      end
    end
    prev_phi2 = phi2;
    was_rst = rst;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic wreg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rreg(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a;
    @(negedge clk); d = reg_rdata;
  endtask

  task automatic setup(input logic [15:0] s, input logic [15:0] d, input logic [15:0] n,
                       input logic down);
    wreg(3'd0, s[7:0]); wreg(3'd1, s[15:8]);
    wreg(3'd2, d[7:0]); wreg(3'd3, d[15:8]);
    wreg(3'd4, n[7:0]); wreg(3'd5, n[15:8]);
    exp_src = s; exp_dst = d; exp_down = down;
    gen++;
  endtask

  task automatic wait_idle();
    logic [7:0] st;
    for (int k = 0; k < 40000; k++) begin
      rreg(3'd7, st);
      if (!st[0]) break;
    end
  endtask

  task automatic run(input logic [15:0] s, input logic [15:0] d, input int n,
                     input logic down, input logic pm, input logic ie);
    logic [7:0] v, h;
    setup(s, d, 16'(n), down);
    wreg(3'd6, {4'b0, ie, pm, down, 1'b1});
    wait_idle();
    rreg(3'd7, v);
    chk(v == 8'h02, "R5", "status after copy", v, 8'h02);
    chk(nbytes == n, "R5", "write slot count", nbytes, n);
    rreg(3'd0, v); rreg(3'd1, h);
    chk({h, v} == stp(s, n, down), "R3", "final source", {h, v}, stp(s, n, down));
    rreg(3'd4, v); rreg(3'd5, h);
    chk({h, v} == 16'h0, "R4", "final count", {h, v}, 0);
    chk(irq == ie, "R6", "irq after done", irq, ie);
    wreg(3'd7, 8'h02);
    rreg(3'd7, v);
    chk(v == 8'h00, "R9", "done cleared", v, 0);
    @(negedge clk);
    chk(irq == 1'b0, "R6", "irq after clear", irq, 0);
  endtask

  initial begin
    logic [7:0] v, h;
    int unsigned sd;
    sd = $urandom(32'd2024);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk(!bus_addr_oe && !bus_data_oe && dack_n && !irq, "R11", "bus idle after reset",
        {bus_addr_oe, bus_data_oe, dack_n, irq}, 4'b0010);
    rreg(3'd7, v);
    chk(v == 8'h00, "R11", "status after reset", v, 0);

    // directed: single byte upward, interrupts on
    run(16'h1100, 16'h2200, 1, 1'b0, 1'b0, 1'b1);

    // R7/R10: paced copy with request held low
    dreq_sel = 0;
    setup(16'h1234, 16'h3400, 16'd3, 1'b0);
    wreg(3'd6, 8'b0000_0101);
    repeat (40) @(negedge clk);
    chk(nbytes == 0, "R7", "no bytes without dreq", nbytes, 0);
    rreg(3'd7, v);
    chk(v == 8'h01, "R7", "still busy waiting", v, 1);
    wreg(3'd0, 8'h99);
    rreg(3'd0, v);
    chk(v == 8'h34, "R10", "source write ignored when busy", v, 8'h34);
    wreg(3'd6, 8'b0000_1011);
    rreg(3'd6, v);
    chk(v == 8'h04, "R10", "control write ignored when busy", v, 8'h04);
    chk(v == 8'h04, "R12", "control readback layout", v, 8'h04);
    dreq_sel = 1;
    wait_idle();
    chk(nbytes == 3, "R7", "bytes after dreq", nbytes, 3);
    wreg(3'd7, 8'h02);

    // R8/R4: zero count walking the source down into page zero
    setup(16'h012C, 16'h9000, 16'd0, 1'b1);
    wreg(3'd6, 8'b0000_1011);
    wait_idle();
    rreg(3'd7, v);
    chk(v == 8'h04, "R8", "error set, done clear", v, 8'h04);
    chk(nbytes == 45, "R8", "bytes before page zero", nbytes, 45);
    rreg(3'd4, v); rreg(3'd5, h);
    chk({h, v} == 16'hFFD3, "R4", "zero count means 65536", {h, v}, 16'hFFD3);
    rreg(3'd0, v); rreg(3'd1, h);
    chk({h, v} == 16'h00FF, "R8", "source stopped at page zero", {h, v}, 16'h00FF);
    @(negedge clk);
    chk(irq == 1'b1, "R6", "irq on error", irq, 1);
    wreg(3'd7, 8'h04);
    rreg(3'd7, v);
    chk(v == 8'h00, "R9", "error cleared", v, 0);
    @(negedge clk);
    chk(irq == 1'b0, "R6", "irq low after error clear", irq, 0);

    // R8: destination inside page zero; error left set for R9 start-clear
    setup(16'h1500, 16'h00F0, 16'd4, 1'b0);
    wreg(3'd6, 8'b0000_0001);
    wait_idle();
    rreg(3'd7, v);
    chk(v == 8'h04, "R8", "error on destination", v, 8'h04);
    chk(nbytes == 0, "R8", "no write to page zero", nbytes, 0);
    rreg(3'd0, v);
    chk(v == 8'h01, "R8", "read slot ran once", v, 8'h01);

    // constrained random copies (run checks that start cleared the error, R9)
    for (int t = 0; t < 10; t++) begin
      int n;
      logic dn, pm, ie;
      logic [15:0] s, d;
      n  = 1 + int'($urandom % 48);
      dn = 1'($urandom % 2);
      pm = 1'($urandom % 2);
      ie = 1'($urandom % 2);
      s  = 16'h1100 + 16'($urandom % 16'h0500);
      d  = 16'h2900 + 16'($urandom % 16'h0500);
      dreq_sel = pm ? 2 : int'($urandom % 3);
      run(s, d, n, dn, pm, ie);
    end

    errors += mon_errs;
    checks += mon_checks;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog: run did not finish act=hung exp=done");
    $display("Result: errors=%0d of %0d checks", errors + mon_errs + 1, checks + mon_checks + 1);
    $finish;
  end
endmodule